// File: doc/BRIEF.md
# Interleaved MSI Vector Interrupt Controller

This block collects message-signalled interrupt events and keeps them as pending bits spread across a set of register groups. An event carries a vector number. Vector `v` is stored in group `v % NUM_GRP` at bit `v / NUM_GRP`, so the bits of one group hold every eighth vector. An event arrives through the inbound `msi_valid`/`msi_data` port, which the transaction layer drives, or through a register write to the doorbell word.

Each group has a pending status word and an enable mask. Writes to the status word clear bits (write-one-to-clear). The enable mask can be reached at a set alias and at a clear alias. Every group drives its own interrupt line through a three-state machine:

- `ST_IDLE`: the line is low and waits for enabled pending bits. The transition **arm** (enabled bits become pending) moves it to `ST_FIRE`.
- `ST_FIRE`: the line is high. The transition **ack** (an end-of-interrupt write for this line) moves it to `ST_HOLD`. The transition **drain** (no enabled bits remain pending) moves it back to `ST_IDLE`.
- `ST_HOLD`: the line is low for one cycle. The transition **refire** (enabled bits are still pending) moves it to `ST_FIRE`. The transition **settle** (nothing is pending) moves it to `ST_IDLE`.

A small legacy section has one pending bit per line. It has the same kind of enables and the same state machine. All the lines share one end-of-interrupt register, which uses an offset code to tell MSI groups apart from legacy lines.

Top module: `msi_intc`

## Requirements
- R1: After reset, every status bit and every enable bit is zero, and `msi_irq` and `intx_irq` are low.
- R2: An event with vector `v < 32` marks bit `v / 8` of group `v % 8` pending in the next cycle. The event can come from `msi_valid`/`msi_data` or from a register write of `v` to offset 0x054. Group `i` status reads at 0x104 + 16·i.
- R3: An event or a doorbell write whose value is 32 or more changes no status bit.
- R4: Writing ones to a status word clears exactly those bits. Zero bits in the write leave their status bits as they are.
- R5: Writing ones at 0x108 + 16·i sets the matching enable bits of group `i`, and writing ones at 0x10C + 16·i clears them. Reading either address returns the current enable mask.
- R6: `msi_irq[i]` rises one cycle after (status AND enable) of group `i` becomes non-zero. It falls one cycle after that value returns to zero.
- R7: Writing `i + 4` to offset 0x050 while `msi_irq[i]` is high drives the line low in the next cycle. The line rises again one cycle later if enabled bits are still pending.
- R8: When an event and a write-one-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R9: While `intx_in[k]` is high, bit 0 of the legacy status at 0x184 + 16·k becomes set. Its enable is set at 0x188 + 16·k and cleared at 0x18C + 16·k. `intx_irq[k]` follows the same state machine, and the end-of-interrupt value for line `k` is `k`.
- R10: `rd_valid` is high in the cycle after `rd_en`, with `rd_data` holding the addressed word. Unmapped addresses, the doorbell and the end-of-interrupt word read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msi_valid | input | 1 | Inbound event strobe |
| msi_data | input | 32 | Vector number of the inbound event |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Register write byte offset |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 12 | Register read byte offset |
| rd_valid | output | 1 | Read data valid, one cycle after `rd_en` |
| rd_data | output | 32 | Read data |
| intx_in | input | 4 | Legacy interrupt request levels |
| msi_irq | output | 8 | One interrupt line per MSI group |
| intx_irq | output | 4 | One interrupt line per legacy line |

## Verification
The hardest case to reach is the tie between an inbound event and a write-one-to-clear on the same status bit. The bench drives `msi_valid` and a status write in the same cycle, with a vector chosen to land on the bit being cleared, and then reads the word back. The refire path is also reached on purpose. Two vectors are made pending in one group but only one is enabled, the group is acknowledged, and the line is sampled in the cycle it drops and in the cycle after. Vectors that decode to bits other than bit 0 confirm the interleaved layout.

// File: rtl/msi_intc_pkg.sv
package msi_intc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FIRE = 2'd1,
        ST_HOLD = 2'd2
    } irq_state_e;

    localparam logic [11:0] OFS_EOI      = 12'h050;
    localparam logic [11:0] OFS_DOORBELL = 12'h054;
    localparam logic [11:0] OFS_MSI_BASE = 12'h100;
    localparam logic [11:0] OFS_LEG_BASE = 12'h180;
    localparam logic [3:0]  SUB_STAT     = 4'h4;
    localparam logic [3:0]  SUB_ESET     = 4'h8;
    localparam logic [3:0]  SUB_ECLR     = 4'hC;
    localparam int          EOI_MSI_BASE = 4;
endpackage

// File: rtl/irq_line_fsm.sv
module irq_line_fsm
    import msi_intc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    input  logic eoi_i,
    output logic irq_o
);
    irq_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (active_i) state_d = ST_FIRE;
            ST_FIRE: begin
                if (eoi_i)          state_d = ST_HOLD;
                else if (!active_i) state_d = ST_IDLE;
            end
            ST_HOLD: state_d = active_i ? ST_FIRE : ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        irq_o = (state_q == ST_FIRE);
    end

    // R7
    eoi_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && eoi_i) |=> !irq_o);

    // R7
    refire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD && active_i) |=> irq_o);

    // R6
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_o && !active_i) |=> !irq_o);
endmodule

// File: rtl/pend_bank.sv
module pend_bank #(
    parameter int NUM_SLOT = 8,
    parameter int SLOT_W   = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_SLOT*SLOT_W-1:0]   set_i,
    input  logic [NUM_SLOT*SLOT_W-1:0]   w1c_i,
    input  logic [NUM_SLOT*SLOT_W-1:0]   eset_i,
    input  logic [NUM_SLOT*SLOT_W-1:0]   eclr_i,
    output logic [NUM_SLOT*SLOT_W-1:0]   stat_o,
    output logic [NUM_SLOT*SLOT_W-1:0]   en_o,
    output logic [NUM_SLOT-1:0]          active_o
);
    localparam int W = NUM_SLOT * SLOT_W;

    logic [W-1:0] stat_q, en_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
            en_q   <= '0;
        end else begin
            stat_q <= (stat_q & ~w1c_i) | set_i;
            en_q   <= (en_q | eset_i) & ~eclr_i;
        end
    end

    for (genvar s = 0; s < NUM_SLOT; s++) begin : g_slot
        assign active_o[s] = |(stat_q[s*SLOT_W +: SLOT_W] & en_q[s*SLOT_W +: SLOT_W]);
    end

    assign stat_o = stat_q;
    assign en_o   = en_q;

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(set_i & w1c_i)) |=> ((stat_q & $past(set_i & w1c_i)) == $past(set_i & w1c_i)));

    // R4
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(w1c_i & ~set_i)) |=> ((stat_q & $past(w1c_i & ~set_i)) == '0));

    // R5
    en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(eset_i & ~eclr_i)) |=> ((en_q & $past(eset_i & ~eclr_i)) == $past(eset_i & ~eclr_i)));
endmodule

// File: rtl/msi_intc.sv
module msi_intc
    import msi_intc_pkg::*;
#(
    parameter int NUM_VEC = 32,
    parameter int NUM_GRP = 8,
    parameter int NUM_LEG = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               msi_valid,
    input  logic [31:0]        msi_data,
    input  logic               wr_en,
    input  logic [11:0]        wr_addr,
    input  logic [31:0]        wr_data,
    input  logic               rd_en,
    input  logic [11:0]        rd_addr,
    output logic               rd_valid,
    output logic [31:0]        rd_data,
    input  logic [NUM_LEG-1:0] intx_in,
    output logic [NUM_GRP-1:0] msi_irq,
    output logic [NUM_LEG-1:0] intx_irq
);
    localparam int GRP_BITS = NUM_VEC / NUM_GRP;

    logic [NUM_VEC-1:0] msi_set, msi_w1c, msi_eset, msi_eclr, msi_stat, msi_en;
    logic [NUM_LEG-1:0] leg_w1c, leg_eset, leg_eclr, leg_stat, leg_en;
    logic [NUM_GRP-1:0] msi_active, msi_eoi;
    logic [NUM_LEG-1:0] leg_active, leg_eoi;

    logic [11:0] w_moff, w_loff, r_moff, r_loff;
    logic        w_mhit, w_lhit, r_mhit, r_lhit;
    logic [7:0]  w_mslot, w_lslot, r_mslot, r_lslot;

    assign w_moff  = wr_addr - OFS_MSI_BASE;
    assign w_loff  = wr_addr - OFS_LEG_BASE;
    assign r_moff  = rd_addr - OFS_MSI_BASE;
    assign r_loff  = rd_addr - OFS_LEG_BASE;
    assign w_mhit  = (wr_addr >= OFS_MSI_BASE) && (w_moff < 12'(16 * NUM_GRP));
    assign w_lhit  = (wr_addr >= OFS_LEG_BASE) && (w_loff < 12'(16 * NUM_LEG));
    assign r_mhit  = (rd_addr >= OFS_MSI_BASE) && (r_moff < 12'(16 * NUM_GRP));
    assign r_lhit  = (rd_addr >= OFS_LEG_BASE) && (r_loff < 12'(16 * NUM_LEG));
    assign w_mslot = 8'(w_moff >> 4);
    assign w_lslot = 8'(w_loff >> 4);
    assign r_mslot = 8'(r_moff >> 4);
    assign r_lslot = 8'(r_loff >> 4);

    // MSI write decode: vector v lands in group v % NUM_GRP, bit v / NUM_GRP
    always_comb begin
        msi_set  = '0;
        msi_w1c  = '0;
        msi_eset = '0;
        msi_eclr = '0;
        msi_eoi  = '0;
        for (int g = 0; g < NUM_GRP; g++) begin
            for (int b = 0; b < GRP_BITS; b++) begin
                if (msi_valid && msi_data == 32'(b * NUM_GRP + g))
                    msi_set[g*GRP_BITS + b] = 1'b1;
                if (wr_en && wr_addr == OFS_DOORBELL && wr_data == 32'(b * NUM_GRP + g))
                    msi_set[g*GRP_BITS + b] = 1'b1;
                if (wr_en && w_mhit && w_mslot == 8'(g)) begin
                    if (wr_addr[3:0] == SUB_STAT) msi_w1c[g*GRP_BITS + b]  = wr_data[b];
                    if (wr_addr[3:0] == SUB_ESET) msi_eset[g*GRP_BITS + b] = wr_data[b];
                    if (wr_addr[3:0] == SUB_ECLR) msi_eclr[g*GRP_BITS + b] = wr_data[b];
                end
            end
            msi_eoi[g] = wr_en && wr_addr == OFS_EOI && wr_data == 32'(g + EOI_MSI_BASE);
        end
    end

    // Legacy write decode
    always_comb begin
        leg_w1c  = '0;
        leg_eset = '0;
        leg_eclr = '0;
        leg_eoi  = '0;
        for (int k = 0; k < NUM_LEG; k++) begin
            if (wr_en && w_lhit && w_lslot == 8'(k)) begin
                if (wr_addr[3:0] == SUB_STAT) leg_w1c[k]  = wr_data[0];
                if (wr_addr[3:0] == SUB_ESET) leg_eset[k] = wr_data[0];
                if (wr_addr[3:0] == SUB_ECLR) leg_eclr[k] = wr_data[0];
            end
            leg_eoi[k] = wr_en && wr_addr == OFS_EOI && wr_data == 32'(k);
        end
    end

    pend_bank #(.NUM_SLOT(NUM_GRP), .SLOT_W(GRP_BITS)) u_msi_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (msi_set),
        .w1c_i    (msi_w1c),
        .eset_i   (msi_eset),
        .eclr_i   (msi_eclr),
        .stat_o   (msi_stat),
        .en_o     (msi_en),
        .active_o (msi_active)
    );

    pend_bank #(.NUM_SLOT(NUM_LEG), .SLOT_W(1)) u_leg_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (intx_in),
        .w1c_i    (leg_w1c),
        .eset_i   (leg_eset),
        .eclr_i   (leg_eclr),
        .stat_o   (leg_stat),
        .en_o     (leg_en),
        .active_o (leg_active)
    );

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_msi_line
        irq_line_fsm u_fsm (
            .clk      (clk),
            .rst_n    (rst_n),
            .active_i (msi_active[g]),
            .eoi_i    (msi_eoi[g]),
            .irq_o    (msi_irq[g])
        );
    end

    for (genvar k = 0; k < NUM_LEG; k++) begin : g_leg_line
        irq_line_fsm u_fsm (
            .clk      (clk),
            .rst_n    (rst_n),
            .active_i (leg_active[k]),
            .eoi_i    (leg_eoi[k]),
            .irq_o    (intx_irq[k])
        );
    end

    // Read mux, registered
    logic [31:0] rd_mux;
    always_comb begin
        rd_mux = '0;
        for (int g = 0; g < NUM_GRP; g++) begin
            if (r_mhit && r_mslot == 8'(g)) begin
                if (rd_addr[3:0] == SUB_STAT)
                    rd_mux = 32'(msi_stat[g*GRP_BITS +: GRP_BITS]);
                if (rd_addr[3:0] == SUB_ESET || rd_addr[3:0] == SUB_ECLR)
                    rd_mux = 32'(msi_en[g*GRP_BITS +: GRP_BITS]);
            end
        end
        for (int k = 0; k < NUM_LEG; k++) begin
            if (r_lhit && r_lslot == 8'(k)) begin
                if (rd_addr[3:0] == SUB_STAT)
                    rd_mux = 32'(leg_stat[k]);
                if (rd_addr[3:0] == SUB_ESET || rd_addr[3:0] == SUB_ECLR)
                    rd_mux = 32'(leg_en[k]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            rd_data  <= rd_en ? rd_mux : '0;
        end
    end

    // R3
    big_vec_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msi_valid && msi_data >= 32'(NUM_VEC) && !wr_en) |=> $stable(msi_stat));

    // R10
    rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (msi_irq == '0 && intx_irq == '0));
endmodule

// File: tb/msi_intc_tb_top.sv
module msi_intc_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        msi_valid = 1'b0;
    logic [31:0] msi_data = '0;
    logic        wr_en = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [11:0] rd_addr = '0;
    logic        rd_valid;
    logic [31:0] rd_data;
    logic [3:0]  intx_in = '0;
    logic [7:0]  msi_irq;
    logic [3:0]  intx_irq;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    msi_intc dut_i (
        .clk(clk), .rst_n(rst_n),
        .msi_valid(msi_valid), .msi_data(msi_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .intx_in(intx_in), .msi_irq(msi_irq), .intx_irq(intx_irq)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Monitor: pops expected read results as the design returns them
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                chk("R10 unexpected rd_valid", 32'd1, 32'd0);
            end else begin
                chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
            end
        end
    end

    task automatic reg_wr(logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_rd(logic [11:0] a, logic [31:0] e, string tag);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic msi_send(logic [31:0] v);
        @(negedge clk);
        msi_valid = 1'b1; msi_data = v;
        @(negedge clk);
        msi_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        chk("watchdog", 32'd1, 32'd0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 msi_irq", 32'(msi_irq), 32'd0);
        chk("R1 intx_irq", 32'(intx_irq), 32'd0);
        reg_rd(12'h104, 32'h0, "R1 status0");
        reg_rd(12'h108, 32'h0, "R1 enable0");

        // R5 enable aliases
        reg_wr(12'h108, 32'hF);
        reg_wr(12'h10C, 32'h2);
        reg_rd(12'h108, 32'hD, "R5 set alias read");
        reg_rd(12'h10C, 32'hD, "R5 clear alias read");

        // R2/R6: vector 8 lands in group 0 bit 1, which is disabled
        msi_send(32'd8);
        @(negedge clk);
        chk("R6 disabled bit no irq", 32'(msi_irq[0]), 32'd0);
        reg_rd(12'h104, 32'h2, "R2 vector 8 status0");

        // R6: vector 16 lands in group 0 bit 2, enabled
        msi_send(32'd16);
        chk("R6 not yet high", 32'(msi_irq[0]), 32'd0);
        @(negedge clk);
        chk("R6 irq high", 32'(msi_irq[0]), 32'd1);

        // R2 interleave: vector 13 -> group 5 bit 1
        msi_send(32'd13);
        reg_rd(12'h154, 32'h2, "R2 vector 13 status5");
        chk("R6 group5 disabled", 32'(msi_irq[5]), 32'd0);

        // R7 EOI with work still pending
        reg_wr(12'h050, 32'd4);
        chk("R7 drop after eoi", 32'(msi_irq[0]), 32'd0);
        @(negedge clk);
        chk("R7 refire", 32'(msi_irq[0]), 32'd1);

        // R4 W1C of bit 2 only
        reg_wr(12'h104, 32'h4);
        @(negedge clk);
        chk("R4 irq falls after clear", 32'(msi_irq[0]), 32'd0);
        reg_rd(12'h104, 32'h2, "R4 other bit kept");

        // R2 doorbell via register write
        reg_wr(12'h054, 32'd31);
        reg_rd(12'h174, 32'h8, "R2 doorbell reg vector 31");

        // R3 out-of-range values ignored
        msi_send(32'd32);
        msi_send(32'hFFFF_FFFF);
        reg_wr(12'h054, 32'd40);
        for (int g = 0; g < 8; g++) begin
            logic [31:0] e;
            e = (g == 0 || g == 5) ? 32'h2 : (g == 7 ? 32'h8 : 32'h0);
            reg_rd(12'(12'h104 + 16 * g), e, "R3 status unchanged");
        end

        // R8 same-cycle event and W1C on group 2 bit 0 (vector 2)
        msi_send(32'd2);
        @(negedge clk);
        msi_valid = 1'b1; msi_data = 32'd2;
        wr_en = 1'b1; wr_addr = 12'h124; wr_data = 32'h1;
        @(negedge clk);
        msi_valid = 1'b0; wr_en = 1'b0;
        reg_rd(12'h124, 32'h1, "R8 event wins");
        reg_wr(12'h124, 32'h1);
        reg_rd(12'h124, 32'h0, "R4 plain clear");

        // R7 EOI with nothing pending: line stays low
        reg_wr(12'h168, 32'h1);
        msi_send(32'd6);
        @(negedge clk);
        chk("R6 group6 high", 32'(msi_irq[6]), 32'd1);
        reg_wr(12'h16C, 32'h1);
        reg_wr(12'h050, 32'd10);
        chk("R7 no refire", 32'(msi_irq[6]), 32'd0);
        @(negedge clk);
        chk("R7 stays low", 32'(msi_irq[6]), 32'd0);

        // R9 legacy line 1
        @(negedge clk);
        intx_in[1] = 1'b1;
        @(negedge clk);
        intx_in[1] = 1'b0;
        reg_rd(12'h194, 32'h1, "R9 legacy status");
        chk("R9 disabled legacy low", 32'(intx_irq[1]), 32'd0);
        reg_wr(12'h198, 32'h1);
        @(negedge clk);
        chk("R9 legacy irq high", 32'(intx_irq[1]), 32'd1);
        reg_wr(12'h050, 32'd1);
        chk("R9 legacy eoi drop", 32'(intx_irq[1]), 32'd0);
        @(negedge clk);
        chk("R9 legacy refire", 32'(intx_irq[1]), 32'd1);
        reg_wr(12'h194, 32'h1);
        @(negedge clk);
        chk("R9 legacy cleared low", 32'(intx_irq[1]), 32'd0);
        reg_rd(12'h19C, 32'h1, "R9 legacy enable alias");
        reg_rd(12'h194, 32'h0, "R9 legacy status cleared");

        // R10 unmapped and write-only words read zero
        reg_rd(12'h300, 32'h0, "R10 unmapped");
        reg_rd(12'h050, 32'h0, "R10 eoi reads zero");
        reg_rd(12'h054, 32'h0, "R10 doorbell reads zero");

        repeat (3) @(negedge clk);
        chk("R10 queue drained", 32'(exp_q.size()), 32'd0);
        finish_run();
    end
endmodule